// File: doc/BRIEF.md
# Incremental Positional Score Unit

The unit keeps a running positional score for a game-tree search engine and updates it in one clock cycle each time a move is made or taken back. Each move is described by the moving piece, its origin and destination squares, an optional captured piece, and a flag that tells whether the mover is white. From these fields the unit reads three signed table entries in parallel, forms the signed score change, and adds it to the running total. The total is the fast score that search control reads.

Three small lookup memories hold the positional values. Two are colour-specific, one for white and one for black, with 512 entries each. One is shared by both colours and has 1024 entries. Every entry is a signed 10-bit number. The mover's colour steers the addresses into the two colour tables and selects which of their outputs feeds which term. This lets the origin term and the capture term come from opposite colour tables in the same cycle. The table contents are loaded through a plain write port while no move is being applied.

Top module: `pst_score_unit`

## Requirements
- R1: After synchronous reset, `fast_score` is 0 and `collide_err` is 0.
- R2: A write with `tw_en` high and `mv_valid` low stores `tw_data` into the table picked by `tw_sel`: 0 selects the white table, 1 the black table and 2 the shared table. The colour tables use address bits [8:0], laid out as {piece[2:0], square[5:0]}. The shared table uses bits [9:0], laid out as {is_white, piece[2:0], square[5:0]}.
- R3: For a move (`mv_valid` high, `mv_undo` low), the change is computed from signed 10-bit entries. It equals shared[{mv_aggr_white, mv_aggr, mv_to}] minus own-colour[{mv_aggr, mv_from}] plus opposite-colour[{mv_victim, mv_to}].
- R4: `fast_score` takes its new value at the first clock edge after the move is presented and holds its value in every cycle in which `mv_valid` is low.
- R5: With `mv_undo` high, the same change is subtracted instead of added, so a move followed by its undo returns `fast_score` exactly to its earlier value.
- R6: A victim code of 0 means no capture, and the capture term is then zero whatever the tables hold.
- R7: When `mv_aggr_white` is 1, the origin term is read from the white table and the capture term from the black table. When it is 0, the two tables swap roles.
- R8: A table write presented in the same cycle as a move is dropped, and `collide_err` is high for exactly the following cycle.
- R9: `fast_score` is a 16-bit two's-complement total that wraps modulo 65536.
- R10: A write with `tw_sel` = 3 changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_valid | input | 1 | Move descriptor present this cycle |
| mv_undo | input | 1 | Take back the move instead of making it |
| mv_aggr_white | input | 1 | Moving piece is white |
| mv_aggr | input | 3 | Moving piece code |
| mv_from | input | 6 | Origin square |
| mv_to | input | 6 | Destination square |
| mv_victim | input | 3 | Captured piece code, 0 for none |
| tw_en | input | 1 | Table write strobe |
| tw_sel | input | 2 | Table select: 0 white, 1 black, 2 shared, 3 none |
| tw_addr | input | 10 | Table write address |
| tw_data | input | 10 | Signed table value |
| fast_score | output | 16 | Running positional score |
| collide_err | output | 1 | A write collided with a move in the previous cycle |

## Verification
The bench builds the unit with its default parameters: 3-bit piece codes, 6-bit squares, 10-bit entries and a 16-bit score. With these values every entry of all three tables can be loaded in about two thousand cycles. Loading extreme entries of ±511 then drives the total past 32767 within a few dozen moves. So wraparound, full-range sign extension and exact restoration by undo after wrap are all tested, alongside random make, undo and colliding-write traffic.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [1:0] {
    TBL_WHITE  = 2'd0,
    TBL_BLACK  = 2'd1,
    TBL_SHARED = 2'd2,
    TBL_NONE   = 2'd3
  } tbl_sel_e;

  localparam int NUM_COLOR_TBL = 2;
endpackage

// File: rtl/pst_ram.sv
// Single write port, asynchronous read: maps to distributed RAM so the
// three lookups and the accumulation fit in one cycle.
module pst_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pst_delta.sv
// Address steering and signed change for one move.
module pst_delta #(
  parameter int PC_W    = 3,
  parameter int SQ_W    = 6,
  parameter int VAL_W   = 10,
  parameter int DELTA_W = VAL_W + 2
) (
  input  logic                    aggr_white,
  input  logic [PC_W-1:0]         aggr,
  input  logic [SQ_W-1:0]         from_sq,
  input  logic [SQ_W-1:0]         to_sq,
  input  logic [PC_W-1:0]         victim,
  output logic [PC_W+SQ_W-1:0]    white_raddr,
  output logic [PC_W+SQ_W-1:0]    black_raddr,
  output logic [PC_W+SQ_W:0]      shared_raddr,
  input  logic [VAL_W-1:0]        white_val,
  input  logic [VAL_W-1:0]        black_val,
  input  logic [VAL_W-1:0]        shared_val,
  output logic signed [DELTA_W-1:0] delta
);
  localparam int EXT_W = DELTA_W - VAL_W;

  logic [PC_W+SQ_W-1:0] own_addr, opp_addr;
  logic [VAL_W-1:0]     own_val, opp_val;
  logic signed [DELTA_W-1:0] to_term, from_term, cap_term;

  assign own_addr = {aggr, from_sq};
  assign opp_addr = {victim, to_sq};

  // colour-steered addressing: mover's table gets the origin lookup
  assign white_raddr  = aggr_white ? own_addr : opp_addr;
  assign black_raddr  = aggr_white ? opp_addr : own_addr;
  assign shared_raddr = {aggr_white, aggr, to_sq};

  assign own_val = aggr_white ? white_val : black_val;
  assign opp_val = aggr_white ? black_val : white_val;

  assign to_term   = {{EXT_W{shared_val[VAL_W-1]}}, shared_val};
  assign from_term = {{EXT_W{own_val[VAL_W-1]}}, own_val};
  assign cap_term  = (victim == '0) ? '0 : {{EXT_W{opp_val[VAL_W-1]}}, opp_val};

  assign delta = to_term - from_term + cap_term;
endmodule

// File: rtl/pst_score_unit.sv
module pst_score_unit #(
  parameter int PC_W    = 3,
  parameter int SQ_W    = 6,
  parameter int VAL_W   = 10,
  parameter int SCORE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mv_valid,
  input  logic               mv_undo,
  input  logic               mv_aggr_white,
  input  logic [PC_W-1:0]    mv_aggr,
  input  logic [SQ_W-1:0]    mv_from,
  input  logic [SQ_W-1:0]    mv_to,
  input  logic [PC_W-1:0]    mv_victim,
  input  logic               tw_en,
  input  logic [1:0]         tw_sel,
  input  logic [PC_W+SQ_W:0] tw_addr,
  input  logic [VAL_W-1:0]   tw_data,
  output logic [SCORE_W-1:0] fast_score,
  output logic               collide_err
);
  import pst_pkg::*;

  localparam int CA_W    = PC_W + SQ_W;
  localparam int SA_W    = CA_W + 1;
  localparam int DELTA_W = VAL_W + 2;
  localparam int LIMIT   = 3 * (1 << (VAL_W - 1));

  tbl_sel_e sel;
  logic     wr_ok;
  logic [CA_W-1:0]  col_raddr [NUM_COLOR_TBL];
  logic [VAL_W-1:0] col_rdata [NUM_COLOR_TBL];
  logic [NUM_COLOR_TBL-1:0] col_we;
  logic             shared_we;
  logic [SA_W-1:0]  shared_raddr;
  logic [VAL_W-1:0] shared_rdata;
  logic signed [DELTA_W-1:0] delta;
  logic [SCORE_W-1:0] delta_ext;

  assign sel   = tbl_sel_e'(tw_sel);
  assign wr_ok = tw_en && !mv_valid;   // R8: moves win over writes

  genvar k;
  generate
    for (k = 0; k < NUM_COLOR_TBL; k++) begin : g_color
      assign col_we[k] = wr_ok && (sel == tbl_sel_e'(k));
      pst_ram #(.ADDR_W(CA_W), .DATA_W(VAL_W)) u_tbl (
        .clk   (clk),
        .we    (col_we[k]),
        .waddr (tw_addr[CA_W-1:0]),
        .wdata (tw_data),
        .raddr (col_raddr[k]),
        .rdata (col_rdata[k])
      );
    end
  endgenerate

  assign shared_we = wr_ok && (sel == TBL_SHARED);

  pst_ram #(.ADDR_W(SA_W), .DATA_W(VAL_W)) u_shared (
    .clk   (clk),
    .we    (shared_we),
    .waddr (tw_addr),
    .wdata (tw_data),
    .raddr (shared_raddr),
    .rdata (shared_rdata)
  );

  pst_delta #(.PC_W(PC_W), .SQ_W(SQ_W), .VAL_W(VAL_W), .DELTA_W(DELTA_W)) u_delta (
    .aggr_white   (mv_aggr_white),
    .aggr         (mv_aggr),
    .from_sq      (mv_from),
    .to_sq        (mv_to),
    .victim       (mv_victim),
    .white_raddr  (col_raddr[TBL_WHITE]),
    .black_raddr  (col_raddr[TBL_BLACK]),
    .shared_raddr (shared_raddr),
    .white_val    (col_rdata[TBL_WHITE]),
    .black_val    (col_rdata[TBL_BLACK]),
    .shared_val   (shared_rdata),
    .delta        (delta)
  );

  assign delta_ext = {{(SCORE_W-DELTA_W){delta[DELTA_W-1]}}, delta};

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_score  <= '0;
      collide_err <= 1'b0;
    end else begin
      if (mv_valid) fast_score <= mv_undo ? fast_score - delta_ext : fast_score + delta_ext;
      collide_err <= mv_valid && tw_en;
    end
  end

  // ---------------- assertions ----------------
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fast_score == '0 && !collide_err));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !mv_valid |=> $stable(fast_score));

  assert_make_adds_R3: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && !mv_undo) |=> fast_score == SCORE_W'($past(fast_score) + $past(delta_ext)));

  assert_undo_subtracts_R5: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && mv_undo) |=> fast_score == SCORE_W'($past(fast_score) - $past(delta_ext)));

  assert_collide_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && tw_en) |=> collide_err);

  assert_no_false_flag_R8: assert property (@(posedge clk) disable iff (rst)
    !(mv_valid && tw_en) |=> !collide_err);

  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> !(shared_we || (col_we != '0)));

  assert_one_table_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({shared_we, col_we}) <= ((tw_en && sel != TBL_NONE) ? 1 : 0));

  always_ff @(posedge clk) begin
    if (!rst && mv_valid)
      assert_delta_bound_R3: assert (delta <= LIMIT && delta >= -LIMIT);
  end
endmodule

// File: tb/test_pst_score_unit.sv
`timescale 1ns/1ps
module test_pst_score_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       mv_valid, mv_undo, mv_aggr_white;
  logic [2:0] mv_aggr, mv_victim;
  logic [5:0] mv_from, mv_to;
  logic       tw_en;
  logic [1:0] tw_sel;
  logic [9:0] tw_addr, tw_data;
  logic [15:0] fast_score;
  logic       collide_err;

  pst_score_unit i_pst_score_unit (
    .clk(clk), .rst(rst), .mv_valid(mv_valid), .mv_undo(mv_undo),
    .mv_aggr_white(mv_aggr_white), .mv_aggr(mv_aggr), .mv_from(mv_from),
    .mv_to(mv_to), .mv_victim(mv_victim), .tw_en(tw_en), .tw_sel(tw_sel),
    .tw_addr(tw_addr), .tw_data(tw_data), .fast_score(fast_score),
    .collide_err(collide_err)
  );

  always #2 clk = ~clk;   // 250 MHz

  int wt[512], bt[512], sh[1024];
  int exp_score = 0;
  bit exp_err = 0;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic int sx10(input int v);
    int m = v & 1023;
    return (m >= 512) ? m - 1024 : m;
  endfunction

  function automatic int pattern(input int i, input int seed);
    return ((i * seed + 13) % 1024) - 512;
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (fast_score !== 16'(exp_score) || collide_err !== exp_err) begin
      miscompares++;
      $display("FAIL %s: score=%0h err=%0b expected score=%0h err=%0b",
               tag, fast_score, collide_err, 16'(exp_score), exp_err);
    end
  endtask

  task automatic step(input bit v, input bit u, input bit w, input int a, input int f,
                      input int t, input int vic, input bit we, input int sel,
                      input int adr, input int dat, input string tag);
    int d;
    @(negedge clk);
    mv_valid = v; mv_undo = u; mv_aggr_white = w; mv_aggr = 3'(a);
    mv_from = 6'(f); mv_to = 6'(t); mv_victim = 3'(vic);
    tw_en = we; tw_sel = 2'(sel); tw_addr = 10'(adr); tw_data = 10'(dat);
    if (v) begin
      d = sh[(int'(w) << 9) | (a << 6) | t];
      d -= w ? wt[(a << 6) | f] : bt[(a << 6) | f];
      if (vic != 0) d += w ? bt[(vic << 6) | t] : wt[(vic << 6) | t];
      exp_score = (u ? exp_score - d : exp_score + d) & 16'hFFFF;
    end
    exp_err = v && we;
    if (we && !v) begin
      case (sel)
        0: wt[adr & 511] = sx10(dat);
        1: bt[adr & 511] = sx10(dat);
        2: sh[adr & 1023] = sx10(dat);
        default: ;
      endcase
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic mv(input bit u, input bit w, input int a, input int f, input int t,
                    input int vic, input string tag);
    step(1, u, w, a, f, t, vic, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int sel, input int adr, input int dat, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, sel, adr, dat, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int s0;
    mv_valid = 0; mv_undo = 0; mv_aggr_white = 0; mv_aggr = 0; mv_from = 0;
    mv_to = 0; mv_victim = 0; tw_en = 0; tw_sel = 0; tw_addr = 0; tw_data = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk); rst = 0;

    // R2: load every table entry; score must hold meanwhile (R4)
    for (int i = 0; i < 512; i++) wr(0, i, pattern(i, 37) & 1023, "R2 load white");
    for (int i = 0; i < 512; i++) wr(1, i, pattern(i, 91) & 1023, "R2 load black");
    for (int i = 0; i < 1024; i++) wr(2, i, pattern(i, 53) & 1023, "R2 load shared");

    // R3/R7 quiet moves of both colours, R6 victim none
    mv(0, 1, 3, 12, 28, 0, "R6 white quiet");
    mv(0, 0, 5, 52, 36, 0, "R7 black quiet");
    idle("R4 hold");
    mv(0, 1, 2, 1, 18, 4, "R3 white capture");
    mv(0, 0, 6, 60, 18, 2, "R7 black capture");
    s0 = exp_score;
    mv(0, 1, 4, 3, 39, 5, "R3 make");
    mv(1, 1, 4, 3, 39, 5, "R5 undo");
    vectors++;
    if (exp_score != s0) begin
      miscompares++;
      $display("FAIL R5: model %0d expected %0d", exp_score, s0);
    end

    // R10: select 3 writes nowhere; read back through moves
    wr(3, 12'h0c4 & 1023, 77, "R10 null write");
    wr(3, 12'h2c4 & 1023, 77, "R10 null write");
    mv(0, 1, 3, 4, 4, 3, "R10 readback white");
    mv(0, 0, 3, 4, 4, 3, "R10 readback black");

    // R8: colliding write dropped and flagged one cycle
    step(1, 0, 1, 1, 9, 17, 0, 1, 2, (1 << 9) | (1 << 6) | 17, 300, "R8 collide");
    idle("R8 flag clears");
    mv(0, 1, 1, 9, 17, 0, "R8 table untouched");

    // R9: extreme entries drive wraparound
    wr(2, (1 << 9) | (7 << 6) | 40, 511, "R9 setup");
    wr(0, (7 << 6) | 8, 512, "R9 setup");
    wr(1, (7 << 6) | 40, 511, "R9 setup");
    s0 = exp_score;
    for (int i = 0; i < 30; i++) mv(0, 1, 7, 8, 40, 7, "R9 wrap up");
    for (int i = 0; i < 30; i++) mv(1, 1, 7, 8, 40, 7, "R9 wrap back");
    vectors++;
    if (exp_score != s0) begin
      miscompares++;
      $display("FAIL R9: model %0d expected %0d", exp_score, s0);
    end

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 6)
        step(1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7),
             $urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 7),
             (r == 0), $urandom_range(0, 3), $urandom_range(0, 1023),
             $urandom_range(0, 1023), "R3 random move");
      else if (r < 9)
        wr($urandom_range(0, 3), $urandom_range(0, 1023), $urandom_range(0, 1023),
           "R2 random write");
      else
        idle("R4 random idle");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule